// File: doc/BRIEF.md
# Pending Request Table with Per-Port Requester Mask

This block is the pending-request store of a content router with a fixed number of ports. Each occupied slot holds a hashed name key together with a bitmask that records which ports have asked for that name. When an interest arrives, the block adds the ingress port's bit to the slot for that key. If no slot holds the key yet, it claims a free slot for the key.

When data arrives, the block searches every slot at once for an exact key match. On a hit it returns the accumulated requester mask, so the forwarding logic can send one copy of the data to each marked port. The matched slot is released in the same cycle. When no slot matches, the block marks the data as spurious so that it can be discarded.

All results are registered and appear in the cycle after the strobe. Key hashing, content caching, packet storage and entry expiry are handled elsewhere.

Top module: `pend_req_table`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `data_hit`, `data_drop`, `table_full` and `data_mask` are all zero. A reset empties the table, so a lookup for any key made after reset reports a drop.
- R2: An interest for a key that is not stored creates a slot whose mask has only bit `int_port` set. Bit i stands for port i, and port 0 is the least significant bit.
- R3: An interest for a key that is already stored ORs `1 << int_port` into that slot's mask.
- R4: An interest from a port whose bit is already set leaves the mask unchanged.
- R5: In the cycle after a `data_valid` strobe whose key equals a stored key in every bit, `data_hit` is 1 and `data_mask` holds the stored mask, which is never zero. Every lookup produces exactly one of `data_hit` and `data_drop`.
- R6: In the cycle after a `data_valid` strobe whose key matches no stored slot, `data_drop` is 1, `data_hit` is 0 and `data_mask` is zero. A key that differs from a stored key in a single bit counts as no match.
- R7: A lookup that hits releases that slot, so a second lookup of the same key reports a drop.
- R8: An interest for an unstored key while every slot is occupied raises `table_full` for one cycle, in the cycle after the strobe, and changes no slot. An interest for a stored key while the table is full updates that key's mask and does not raise `table_full`.
- R9: When a data strobe and an interest strobe share a cycle, the lookup sees the table as it stood before that cycle. If the interest's key is the key being released, it starts a fresh slot holding only its own port bit.
- R10: `data_hit` and `data_drop` are zero in any cycle that does not follow a `data_valid` strobe. `table_full` is zero in any cycle that does not follow an `int_valid` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_valid | input | 1 | Interest strobe |
| int_key | input | KEY_W | Hashed name key of the interest |
| int_port | input | PORT_W | Ingress port of the interest (below NPORT) |
| data_valid | input | 1 | Data lookup strobe |
| data_key | input | KEY_W | Hashed name key of the arriving data |
| data_hit | output | 1 | Lookup found a pending slot |
| data_mask | output | NPORT | Requester mask of the matched slot, zero otherwise |
| data_drop | output | 1 | Data is spurious and should be discarded |
| table_full | output | 1 | New-key interest rejected because no slot was free |

## Verification
The bench builds the table with 4 slots, 16-bit keys and 8 ports. With only 4 slots, the full condition, rejection of a fifth key and slot reuse after release all come up within a few cycles of each other. The 8-port mask is kept, so the lowest and highest bit positions are both exercised. A random phase then draws keys from a pool of six and ports from all eight, sets both strobes in the same cycle often, and compares the design against a behavioural table model on every clock.

// File: rtl/prt_pkg.sv
package prt_pkg;

    // What an interest strobe does to the table in a given cycle.
    typedef enum logic [1:0] {
        INT_IDLE   = 2'd0,
        INT_MERGE  = 2'd1,
        INT_CREATE = 2'd2,
        INT_REJECT = 2'd3
    } int_act_e;

    // What a data strobe reports.
    typedef enum logic [1:0] {
        LK_IDLE = 2'd0,
        LK_HIT  = 2'd1,
        LK_DROP = 2'd2
    } lk_res_e;

    // Registered result of a cycle, carried to the outputs.
    typedef struct packed {
        lk_res_e lk;
        logic    full;
    } prt_flags_t;

    function automatic int_act_e classify_interest(
        input logic strobe,
        input logic live_match,
        input logic slot_free
    );
        if (!strobe)
            return INT_IDLE;
        if (live_match)
            return INT_MERGE;
        if (slot_free)
            return INT_CREATE;
        return INT_REJECT;
    endfunction

    function automatic lk_res_e classify_lookup(
        input logic strobe,
        input logic matched,
        input logic mask_nonzero
    );
        if (!strobe)
            return LK_IDLE;
        if (matched && mask_nonzero)
            return LK_HIT;
        return LK_DROP;
    endfunction

endpackage

// File: rtl/prt_match.sv
module prt_match #(
    parameter int DEPTH = 16,
    parameter int KEY_W = 32
) (
    input  logic [DEPTH-1:0][KEY_W-1:0] slot_key,
    input  logic [DEPTH-1:0]            slot_valid,
    input  logic [KEY_W-1:0]            probe_key,
    output logic [DEPTH-1:0]            match
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = slot_valid[g] && (slot_key[g] == probe_key);
    end
endmodule

// File: rtl/prt_alloc.sv
module prt_alloc #(
    parameter int DEPTH = 16
) (
    input  logic [DEPTH-1:0] free,
    output logic [DEPTH-1:0] grant,
    output logic             any_free
);
    // Lowest free index wins.
    logic [DEPTH:0] taken;

    assign taken[0] = 1'b0;
    for (genvar g = 0; g < DEPTH; g++) begin : g_pri
        assign grant[g]   = free[g] && !taken[g];
        assign taken[g+1] = taken[g] || free[g];
    end
    assign any_free = taken[DEPTH];
endmodule

// File: rtl/prt_entry.sv
module prt_entry #(
    parameter int KEY_W = 32,
    parameter int NPORT = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             create,
    input  logic             retire,
    input  logic             merge,
    input  logic [KEY_W-1:0] new_key,
    input  logic [NPORT-1:0] port_bit,
    output logic             valid,
    output logic [KEY_W-1:0] key,
    output logic [NPORT-1:0] mask
);
    // A create outranks a retire, so a released slot can be reused at once.
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            key   <= '0;
            mask  <= '0;
        end else if (create) begin
            valid <= 1'b1;
            key   <= new_key;
            mask  <= port_bit;
        end else if (retire) begin
            valid <= 1'b0;
            mask  <= '0;
        end else if (merge) begin
            mask  <= mask | port_bit;
        end
    end
endmodule

// File: rtl/pend_req_table.sv
module pend_req_table
    import prt_pkg::*;
#(
    parameter  int DEPTH  = 16,
    parameter  int KEY_W  = 32,
    parameter  int NPORT  = 8,
    localparam int PORT_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              int_valid,
    input  logic [KEY_W-1:0]  int_key,
    input  logic [PORT_W-1:0] int_port,
    input  logic              data_valid,
    input  logic [KEY_W-1:0]  data_key,
    output logic              data_hit,
    output logic [NPORT-1:0]  data_mask,
    output logic              data_drop,
    output logic              table_full
);
    logic [DEPTH-1:0][KEY_W-1:0] slot_key;
    logic [DEPTH-1:0][NPORT-1:0] slot_mask;
    logic [DEPTH-1:0]            slot_valid;

    logic [DEPTH-1:0] int_match, data_match;
    logic [DEPTH-1:0] retire_vec, merge_vec, create_vec;
    logic [DEPTH-1:0] free_vec, grant_vec;
    logic             any_free;
    logic [NPORT-1:0] port_bit;
    logic [NPORT-1:0] found_mask;
    int_act_e         int_act;
    lk_res_e          lk_res;
    prt_flags_t       flags_q;
    logic [NPORT-1:0] mask_q;

    prt_match #(.DEPTH(DEPTH), .KEY_W(KEY_W)) u_int_match (
        .slot_key  (slot_key),
        .slot_valid(slot_valid),
        .probe_key (int_key),
        .match     (int_match)
    );

    prt_match #(.DEPTH(DEPTH), .KEY_W(KEY_W)) u_data_match (
        .slot_key  (slot_key),
        .slot_valid(slot_valid),
        .probe_key (data_key),
        .match     (data_match)
    );

    // Lookup against the state held before this cycle.
    assign retire_vec = data_valid ? data_match : '0;

    always_comb begin
        found_mask = '0;
        for (int i = 0; i < DEPTH; i++)
            if (retire_vec[i])
                found_mask = found_mask | slot_mask[i];
    end

    assign lk_res = classify_lookup(data_valid, |retire_vec, |found_mask);

    // Interest: a slot being released this cycle no longer counts as a match.
    always_comb begin
        port_bit = '0;
        port_bit[int_port] = 1'b1;
    end

    assign free_vec = ~slot_valid | retire_vec;

    prt_alloc #(.DEPTH(DEPTH)) u_alloc (
        .free    (free_vec),
        .grant   (grant_vec),
        .any_free(any_free)
    );

    assign int_act    = classify_interest(int_valid, |(int_match & ~retire_vec), any_free);
    assign merge_vec  = (int_act == INT_MERGE)  ? (int_match & ~retire_vec) : '0;
    assign create_vec = (int_act == INT_CREATE) ? grant_vec : '0;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        prt_entry #(.KEY_W(KEY_W), .NPORT(NPORT)) u_entry (
            .clk     (clk),
            .rst     (rst),
            .create  (create_vec[g]),
            .retire  (retire_vec[g]),
            .merge   (merge_vec[g]),
            .new_key (int_key),
            .port_bit(port_bit),
            .valid   (slot_valid[g]),
            .key     (slot_key[g]),
            .mask    (slot_mask[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '{lk: LK_IDLE, full: 1'b0};
            mask_q  <= '0;
        end else begin
            flags_q <= '{lk: lk_res, full: (int_act == INT_REJECT)};
            mask_q  <= (lk_res == LK_HIT) ? found_mask : '0;
        end
    end

    assign data_hit   = (flags_q.lk == LK_HIT);
    assign data_drop  = (flags_q.lk == LK_DROP);
    assign data_mask  = mask_q;
    assign table_full = flags_q.full;
endmodule

// File: rtl/prt_checker.sv
module prt_checker #(
    parameter  int KEY_W  = 32,
    parameter  int NPORT  = 8,
    localparam int PORT_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              int_valid,
    input logic [PORT_W-1:0] int_port,
    input logic              data_valid,
    input logic              data_hit,
    input logic [NPORT-1:0]  data_mask,
    input logic              data_drop,
    input logic              table_full
);
    assert_port_range_R2: assert property (@(posedge clk) disable iff (rst)
        int_valid |-> (int_port < NPORT));

    assert_hit_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
        data_hit |-> (data_mask != '0));

    assert_one_answer_R5: assert property (@(posedge clk) disable iff (rst)
        $past(data_valid) |-> (data_hit ^ data_drop));

    assert_drop_clean_R6: assert property (@(posedge clk) disable iff (rst)
        data_drop |-> (!data_hit && data_mask == '0));

    assert_full_cause_R8: assert property (@(posedge clk) disable iff (rst)
        table_full |-> $past(int_valid));

    assert_lookup_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(data_valid) |-> !(data_hit || data_drop));
endmodule

bind pend_req_table prt_checker #(.KEY_W(KEY_W), .NPORT(NPORT)) u_chk (.*);

// File: tb/pend_req_table_test.sv
`timescale 1ns/1ps
module pend_req_table_test;
    localparam int DEPTH  = 4;
    localparam int KEY_W  = 16;
    localparam int NPORT  = 8;
    localparam int PORT_W = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              int_valid = 1'b0;
    logic [KEY_W-1:0]  int_key = '0;
    logic [PORT_W-1:0] int_port = '0;
    logic              data_valid = 1'b0;
    logic [KEY_W-1:0]  data_key = '0;
    logic              data_hit, data_drop, table_full;
    logic [NPORT-1:0]  data_mask;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pend_req_table #(.DEPTH(DEPTH), .KEY_W(KEY_W), .NPORT(NPORT)) uut (
        .clk(clk), .rst(rst),
        .int_valid(int_valid), .int_key(int_key), .int_port(int_port),
        .data_valid(data_valid), .data_key(data_key),
        .data_hit(data_hit), .data_mask(data_mask),
        .data_drop(data_drop), .table_full(table_full)
    );

    // Behavioural table model
    logic [KEY_W-1:0] mk [DEPTH];
    logic [NPORT-1:0] mm [DEPTH];
    logic             mv [DEPTH];
    logic             exp_hit = 0, exp_drop = 0, exp_full = 0;
    logic [NPORT-1:0] exp_mask = '0;

    always @(posedge clk) begin
        int ret, hitp, freep;
        exp_hit = 0; exp_drop = 0; exp_full = 0; exp_mask = '0;
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin mv[i] = 0; mm[i] = '0; mk[i] = '0; end
        end else begin
            ret = -1;
            if (data_valid) begin
                for (int i = 0; i < DEPTH; i++)
                    if (mv[i] && mk[i] == data_key) ret = i;
                if (ret >= 0) begin
                    exp_hit = 1; exp_mask = mm[ret]; mv[ret] = 0;
                end else exp_drop = 1;
            end
            if (int_valid) begin
                hitp = -1; freep = -1;
                for (int i = 0; i < DEPTH; i++)
                    if (mv[i] && mk[i] == int_key) hitp = i;
                for (int i = DEPTH - 1; i >= 0; i--)
                    if (!mv[i]) freep = i;
                if (hitp >= 0) mm[hitp] = mm[hitp] | (NPORT'(1) << int_port);
                else if (freep >= 0) begin
                    mv[freep] = 1; mk[freep] = int_key; mm[freep] = NPORT'(1) << int_port;
                end else exp_full = 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison with the model
    always @(negedge clk) begin
        if (!done) begin
            chk("R5 model data_hit", 32'(data_hit), 32'(exp_hit));
            chk("R5 model data_mask", 32'(data_mask), 32'(exp_mask));
            chk("R6 model data_drop", 32'(data_drop), 32'(exp_drop));
            chk("R8 model table_full", 32'(table_full), 32'(exp_full));
        end
    end

    task automatic cyc(input logic iv, input logic [KEY_W-1:0] ik, input int ip,
                       input logic dv, input logic [KEY_W-1:0] dk);
        int_valid  = iv;
        int_key    = ik;
        int_port   = PORT_W'(ip);
        data_valid = dv;
        data_key   = dk;
        @(negedge clk);
    endtask

    task automatic interest(input logic [KEY_W-1:0] k, input int p);
        cyc(1, k, p, 0, '0);
    endtask

    task automatic lookup(input logic [KEY_W-1:0] k);
        cyc(0, '0, 0, 1, k);
    endtask

    task automatic finish_run;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(4ns * 200000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        cyc(0, '0, 0, 0, '0);
        // R1: quiet after reset
        chk("R1 hit", 32'(data_hit), 0);
        chk("R1 drop", 32'(data_drop), 0);
        chk("R1 full", 32'(table_full), 0);
        lookup(16'h0011);
        chk("R1 empty table drops", 32'(data_drop), 1);
        chk("R6 miss mask zero", 32'(data_mask), 0);

        // R2: first interest, port 5 -> bit 5
        interest(16'hB0B0, 5);
        lookup(16'hB0B0);
        chk("R2 single bit", 32'(data_mask), 32'h20);
        // R3 / R4: accumulate ports 3,0,3,7
        interest(16'h1234, 3);
        interest(16'h1234, 0);
        interest(16'h1234, 3);
        interest(16'h1234, 7);
        lookup(16'h1234);
        chk("R3 R4 merged mask", 32'(data_mask), 32'h89);
        chk("R5 hit", 32'(data_hit), 1);
        // R10: idle cycle after a hit
        cyc(0, '0, 0, 0, '0);
        chk("R10 hit cleared", 32'(data_hit), 0);
        chk("R10 drop cleared", 32'(data_drop), 0);
        // R7: released after hit
        lookup(16'h1234);
        chk("R7 second lookup drops", 32'(data_drop), 1);
        // R5 / R6: exact match only
        interest(16'h00F0, 1);
        lookup(16'h00F1);
        chk("R6 one-bit-off key drops", 32'(data_drop), 1);
        lookup(16'h00F0);
        chk("R5 exact key mask", 32'(data_mask), 32'h02);

        // R8: fill the table
        for (int i = 0; i < DEPTH; i++) interest(16'hA000 + 16'(i), i);
        chk("R8 no full while filling", 32'(table_full), 0);
        interest(16'hA00F, 4);
        chk("R8 full raised", 32'(table_full), 1);
        interest(16'hA002, 6);
        chk("R8 merge while full", 32'(table_full), 0);
        lookup(16'hA00F);
        chk("R8 rejected key absent", 32'(data_drop), 1);
        lookup(16'hA002);
        chk("R8 merge applied", 32'(data_mask), 32'h44);
        lookup(16'hA000);
        chk("R8 slot 0 intact", 32'(data_mask), 32'h01);
        lookup(16'hA001);
        chk("R8 slot 1 intact", 32'(data_mask), 32'h02);
        lookup(16'hA003);
        chk("R8 slot 3 intact", 32'(data_mask), 32'h08);

        // R9: same-cycle release and new interest for that key
        interest(16'hD00D, 2);
        cyc(1, 16'hD00D, 4, 1, 16'hD00D);
        chk("R9 lookup sees old mask", 32'(data_mask), 32'h04);
        lookup(16'hD00D);
        chk("R9 fresh slot", 32'(data_mask), 32'h10);

        // R1: reset empties the table
        interest(16'hE0E0, 1);
        rst = 1;
        cyc(0, '0, 0, 0, '0);
        rst = 0;
        cyc(0, '0, 0, 0, '0);
        lookup(16'hE0E0);
        chk("R1 reset cleared table", 32'(data_drop), 1);

        // Random traffic against the model
        for (int n = 0; n < 400; n++) begin
            cyc(($urandom % 3) != 0, 16'($urandom_range(1, 6)), $urandom % NPORT,
                ($urandom % 2) != 0, 16'($urandom_range(1, 6)));
        end
        cyc(0, '0, 0, 0, '0);
        finish_run();
    end
endmodule